// File: doc/BRIEF.md
# Status Register with Write-Protect Lock

This block keeps the eight-bit status register of a serial memory device and rules on every attempt to overwrite it. The serial front-end hands it one-cycle strobes for the decoded commands (write-enable set, write-enable clear, start of a status-write frame, each received data byte, and the rising edge of chip enable) together with the received byte. An active-low write-protect pin level and a busy flag from the program engine complete its inputs.

A status write is accepted only when the write-enable latch is set, the frame carries exactly one data byte, and the lock is not engaged. The lock is engaged when the write-protect pin is low and the lock bit stored in the register is 1. With the pin high, the lock bit has no effect. The lock bit can therefore be frozen in hardware by tying the pin low after it has been set. The block drives the packed status byte for status reads, and drives the two block-protection bits and the lock bit to the array-protection logic.

Top module: `srl_status_top`

## Requirements
- R1: After reset, the lock bit and both protection bits are 1 and the write-enable latch is 0, so `status_byte` reads 8'h8C while `busy_in` is low.
- R2: `status_byte` layout: bit 7 is the lock bit, bit 3 is BP1, bit 2 is BP0, bit 1 is the write-enable latch and bit 0 follows `busy_in`. Bits 6, 5 and 4 always read 0. `bp_out` equals bits 3:2 and `lock_out` equals bit 7.
- R3: A `wren_stb` pulse sets the write-enable latch and a `wrdi_stb` pulse clears it, each visible from the next clock edge.
- R4: With `wp_n` high, an accepted status write copies data bits 7, 3 and 2 into the lock bit, BP1 and BP0, whatever the stored lock bit. The other data bits are discarded.
- R5: With `wp_n` low and the stored lock bit 0, a status write is executed as in R4.
- R6: With `wp_n` low and the stored lock bit 1, a status write is rejected and the lock and protection bits keep their values.
- R7: The write-enable latch is 0 after any status-write frame that had the latch set and exactly one byte, whether that write was accepted or rejected by the lock.
- R8: A status-write frame that arrives while the write-enable latch is 0 changes nothing.
- R9: A status-write frame that ends with zero bytes or with two or more bytes is ignored. The protection bits, the lock bit and the write-enable latch all keep their values.
- R10: `data_stb` and `cs_rise` pulses outside an open status-write frame have no effect on the register.
- R11: `wp_n` is judged in the cycle of the `cs_rise` pulse that closes the frame, not in the cycle the frame opened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n | input | 1 | Write-protect pin level, active low, synchronous to clk |
| wren_stb | input | 1 | Pulse: set the write-enable latch |
| wrdi_stb | input | 1 | Pulse: clear the write-enable latch |
| wrsr_stb | input | 1 | Pulse: a status-write command opened a frame |
| data_stb | input | 1 | Pulse: one data byte received |
| data_byte | input | 8 | Received data byte, valid with data_stb |
| cs_rise | input | 1 | Pulse: chip enable went high, frame closed |
| busy_in | input | 1 | Busy flag from the program/erase engine |
| status_byte | output | 8 | Packed status byte for status reads |
| bp_out | output | 2 | Block-protection bits {BP1, BP0} |
| lock_out | output | 1 | Stored lock bit |

## Verification
The main sweep writes every one of the 256 byte values under all four pairings of pin level and prior lock bit. This separates the single rejecting pairing (pin low, lock set) from the three accepting ones, and also shows that only bits 7, 3 and 2 of the data are kept. Frames with zero, two and three bytes, frames sent with the latch clear, and stray byte or chip-enable strobes each check that nothing changes when a guard fails. A pin that is low while the frame opens and high when it closes, and the reverse, shows which cycle decides.

// File: rtl/srl_pkg.sv
package srl_pkg;
    localparam int SR_W     = 8;
    localparam int BYTE_W   = 8;
    localparam int BP_W     = 2;
    localparam int CNT_W    = 2;
    localparam int LOCK_BIT = 7;
    localparam int BP_HI    = 3;
    localparam int BP_LO    = BP_HI - BP_W + 1;
    localparam int WEL_BIT  = 1;
    localparam int BUSY_BIT = 0;
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(2);

    typedef struct packed {
        logic            lock;
        logic [BP_W-1:0] bp;
    } prot_t;

    typedef enum logic {FS_IDLE, FS_OPEN} frame_state_t;

    localparam prot_t PROT_RESET = '{lock: 1'b1, bp: '1};

    // Lock engaged only when the pin is low and the stored lock bit is set.
    function automatic logic write_allowed(input logic pin_n, input logic lock);
        return pin_n | ~lock;
    endfunction

    function automatic prot_t prot_from_byte(input logic [BYTE_W-1:0] b);
        prot_t p;
        p.lock = b[LOCK_BIT];
        p.bp   = b[BP_HI:BP_LO];
        return p;
    endfunction

    function automatic logic [SR_W-1:0] pack_status(input prot_t p, input logic wel,
                                                    input logic busy);
        logic [SR_W-1:0] s;
        s              = '0;
        s[LOCK_BIT]    = p.lock;
        s[BP_HI:BP_LO] = p.bp;
        s[WEL_BIT]     = wel;
        s[BUSY_BIT]    = busy;
        return s;
    endfunction
endpackage

// File: rtl/srl_frame.sv
module srl_frame
    import srl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              open_stb,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              close_stb,
    output logic              frame_done,
    output logic              frame_single,
    output logic [BYTE_W-1:0] frame_byte
);
    frame_state_t     state;
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= FS_IDLE;
            count      <= '0;
            frame_byte <= '0;
        end else if (open_stb) begin
            state <= FS_OPEN;
            count <= '0;
        end else if (state == FS_OPEN) begin
            if (close_stb) begin
                state <= FS_IDLE;
            end else if (byte_stb) begin
                if (count == '0) frame_byte <= byte_in;
                if (count < CNT_SAT) count <= count + 1'b1;
            end
        end
    end

    assign frame_done   = close_stb && (state == FS_OPEN) && !open_stb;
    assign frame_single = (count == CNT_W'(1));
endmodule

// File: rtl/srl_wel.sv
module srl_wel (
    input  logic clk,
    input  logic rst,
    input  logic set_stb,
    input  logic clr_stb,
    input  logic consume,
    output logic wel
);
    always_ff @(posedge clk) begin
        if (rst)                    wel <= 1'b0;
        else if (consume || clr_stb) wel <= 1'b0;
        else if (set_stb)           wel <= 1'b1;
    end
endmodule

// File: rtl/srl_prot.sv
module srl_prot
    import srl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  prot_t next_val,
    output prot_t prot
);
    always_ff @(posedge clk) begin
        if (rst)       prot <= PROT_RESET;
        else if (load) prot <= next_val;
    end
endmodule

// File: rtl/srl_status_top.sv
module srl_status_top
    import srl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_n,
    input  logic              wren_stb,
    input  logic              wrdi_stb,
    input  logic              wrsr_stb,
    input  logic              data_stb,
    input  logic [BYTE_W-1:0] data_byte,
    input  logic              cs_rise,
    input  logic              busy_in,
    output logic [SR_W-1:0]   status_byte,
    output logic [BP_W-1:0]   bp_out,
    output logic              lock_out
);
    logic              frame_done;
    logic              frame_single;
    logic [BYTE_W-1:0] frame_byte;
    logic              wel;
    logic              attempt;
    logic              commit;
    prot_t             prot;

    srl_frame u_frame (
        .clk(clk), .rst(rst), .open_stb(wrsr_stb), .byte_stb(data_stb),
        .byte_in(data_byte), .close_stb(cs_rise), .frame_done(frame_done),
        .frame_single(frame_single), .frame_byte(frame_byte)
    );

    // A well-formed frame with the latch set is an attempt; the lock decides.
    assign attempt = frame_done && frame_single && wel;
    assign commit  = attempt && write_allowed(wp_n, prot.lock);

    srl_wel u_wel (
        .clk(clk), .rst(rst), .set_stb(wren_stb), .clr_stb(wrdi_stb),
        .consume(attempt), .wel(wel)
    );

    srl_prot u_prot (
        .clk(clk), .rst(rst), .load(commit),
        .next_val(prot_from_byte(frame_byte)), .prot(prot)
    );

    assign status_byte = pack_status(prot, wel, busy_in);
    assign bp_out      = prot.bp;
    assign lock_out    = prot.lock;
endmodule

// File: rtl/srl_checker.sv
module srl_checker (
    input logic       clk,
    input logic       rst,
    input logic       wp_n,
    input logic       wren,
    input logic       wrdi,
    input logic       attempt,
    input logic       frame_done,
    input logic       single,
    input logic       wel,
    input logic       lock,
    input logic [1:0] bp,
    input logic [7:0] status_byte
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (lock && bp == 2'b11 && !wel));

    a_r2_unused_zero: assert property (@(posedge clk) disable iff (rst)
        status_byte[6:4] == 3'b000);

    a_r3_wren_sets: assert property (@(posedge clk) disable iff (rst)
        (wren && !wrdi && !attempt) |=> wel);

    a_r6_lock_holds: assert property (@(posedge clk) disable iff (rst)
        (attempt && !wp_n && lock) |=> $stable({lock, bp}));

    a_r7_wel_dropped: assert property (@(posedge clk) disable iff (rst)
        attempt |=> !wel);

    a_r9_bad_count: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !single && !wren && !wrdi) |=> ($stable({lock, bp}) && $stable(wel)));
endmodule

bind srl_status_top srl_checker u_chk (
    .clk(clk), .rst(rst), .wp_n(wp_n), .wren(wren_stb), .wrdi(wrdi_stb),
    .attempt(attempt), .frame_done(frame_done), .single(frame_single),
    .wel(wel), .lock(lock_out), .bp(bp_out), .status_byte(status_byte)
);

// File: tb/sim_srl_status_top.sv
module sim_srl_status_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wp_n = 1'b1, wren_stb = 1'b0, wrdi_stb = 1'b0, wrsr_stb = 1'b0;
    logic       data_stb = 1'b0, cs_rise = 1'b0, busy_in = 1'b0;
    logic [7:0] data_byte = 8'h00;
    logic [7:0] status_byte;
    logic [1:0] bp_out;
    logic       lock_out;

    int checks = 0;
    int fails  = 0;
    logic       m_lock, m_wel;
    logic [1:0] m_bp;

    always #5 clk = ~clk;

    srl_status_top u0 (
        .clk(clk), .rst(rst), .wp_n(wp_n), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
        .wrsr_stb(wrsr_stb), .data_stb(data_stb), .data_byte(data_byte),
        .cs_rise(cs_rise), .busy_in(busy_in), .status_byte(status_byte),
        .bp_out(bp_out), .lock_out(lock_out)
    );

    task automatic check(input string tag);
        logic [7:0] exp;
        exp = {m_lock, 3'b000, m_bp, m_wel, busy_in};
        checks++;
        if (status_byte !== exp || bp_out !== m_bp || lock_out !== m_lock) begin
            fails++;
            $display("FAIL %s: status=%h bp=%b lock=%b expected status=%h bp=%b lock=%b",
                     tag, status_byte, bp_out, lock_out, exp, m_bp, m_lock);
        end
    endtask

    task automatic pulse_wren();
        wren_stb = 1'b1; @(negedge clk); wren_stb = 1'b0;
        m_wel = 1'b1;
    endtask

    task automatic pulse_wrdi();
        wrdi_stb = 1'b1; @(negedge clk); wrdi_stb = 1'b0;
        m_wel = 1'b0;
    endtask

    // Frame: open with pin level wp_open, send nbytes, close with pin level wp_close.
    task automatic do_wrsr(input int nbytes, input logic [7:0] d,
                           input logic wp_open, input logic wp_close);
        wp_n = wp_open;
        wrsr_stb = 1'b1; @(negedge clk); wrsr_stb = 1'b0;
        for (int i = 0; i < nbytes; i++) begin
            data_byte = d ^ 8'(i * 8'h5A);
            data_stb = 1'b1; @(negedge clk); data_stb = 1'b0;
        end
        wp_n = wp_close;
        cs_rise = 1'b1; @(negedge clk); cs_rise = 1'b0;
        if (nbytes == 1 && m_wel) begin
            if (wp_close || !m_lock) begin
                m_lock = d[7];
                m_bp   = d[3:2];
            end
            m_wel = 1'b0;
        end
    endtask

    initial begin
        m_lock = 1'b1; m_bp = 2'b11; m_wel = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state 8C");

        pulse_wren();
        check("R3 wren sets latch");
        pulse_wrdi();
        check("R3 wrdi clears latch");

        do_wrsr(1, 8'h00, 1'b1, 1'b1);
        check("R8 latch clear, frame ignored");

        // Main sweep: every byte under every pin level and prior lock value.
        for (int wp = 0; wp < 2; wp++) begin
            for (int pl = 0; pl < 2; pl++) begin
                for (int d = 0; d < 256; d++) begin
                    pulse_wren();
                    do_wrsr(1, {pl[0], 7'h0C}, 1'b1, 1'b1);
                    busy_in = d[0];
                    pulse_wren();
                    do_wrsr(1, d[7:0], wp[0], wp[0]);
                    if (wp == 0 && pl == 1)      check("R6 locked write rejected");
                    else if (wp == 0)            check("R5 pin low lock clear accepted");
                    else                         check("R4 pin high write accepted, R2 layout, R7 latch");
                end
            end
        end
        busy_in = 1'b0;

        // R9: wrong byte counts with the latch set.
        pulse_wren();
        do_wrsr(0, 8'h00, 1'b1, 1'b1);
        check("R9 zero bytes ignored");
        do_wrsr(2, 8'h00, 1'b1, 1'b1);
        check("R9 two bytes ignored");
        do_wrsr(3, 8'h80, 1'b1, 1'b1);
        check("R9 three bytes ignored");

        // R10: stray strobes outside a frame.
        data_byte = 8'h00;
        data_stb = 1'b1; @(negedge clk); data_stb = 1'b0;
        cs_rise  = 1'b1; @(negedge clk); cs_rise  = 1'b0;
        check("R10 stray byte and close ignored");

        // R11: the pin level at close decides.
        do_wrsr(1, 8'h80, 1'b1, 1'b1);
        check("R11 setup lock set");
        pulse_wren();
        do_wrsr(1, 8'h04, 1'b1, 1'b0);
        check("R11 pin low at close rejects");
        pulse_wren();
        do_wrsr(1, 8'h08, 1'b0, 1'b1);
        check("R11 pin high at close accepts");

        rst = 1'b1; @(negedge clk); rst = 1'b0;
        m_lock = 1'b1; m_bp = 2'b11; m_wel = 1'b0;
        @(negedge clk);
        check("R1 reset after activity");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule